// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead-Time Insertion

This block turns one pulse-width command, a rotation-direction select and a bridge-disable flag into the four gate enables of a full bridge. Only the left leg is modulated. Its low-side and high-side switches follow the command in a complementary way, and every hand-over between them passes through a programmable interval in which both switches are off. The right leg does not switch at the PWM rate. It holds either its high side (forward) or its low side (reverse) for as long as the direction stays the same.

Each leg is a small Moore state machine with its own dwell timer. The left leg has four states. `L_LOW_ON` has the low side on. `L_RISE_GAP` has both switches off on the way up. `L_HIGH_ON` has the high side on. `L_FALL_GAP` has both switches off on the way down. Its transitions are:
- qualify (`L_LOW_ON`→`L_RISE_GAP`, when the effective command has been held for `DEAD_CYC` cycles);
- arm (`L_RISE_GAP`→`L_HIGH_ON`, when the gap expires with the command still high);
- abort (`L_RISE_GAP`→`L_FALL_GAP`, when the command drops during the gap);
- release (`L_HIGH_ON`→`L_FALL_GAP`, when the command drops);
- settle (`L_FALL_GAP`→`L_LOW_ON`, when the gap expires).

The right leg has three states: `R_FWD_ON`, `R_REV_ON` and `R_SWAP_GAP`. It takes swap (an on-state to `R_SWAP_GAP` when the direction input disagrees with the state) and land (`R_SWAP_GAP` to the on-state that the direction input selects when the gap expires). While the disable flag is high, the effective command is zero.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are 0. Both legs come out of reset in their gap state, so the left low side and the selected right switch turn on after the `DEAD_CYC`-th rising clock edge following release.
- R2: The outputs are complementary at rest. A command held low keeps only `gate_ll` on in the left leg, and a command held high long enough keeps only `gate_lh` on.
- R3: After the command rises, `gate_ll` turns off at the `DEAD_CYC`-th edge that samples it high. Both left outputs then stay off for `DEAD_CYC` cycles, and `gate_lh` turns on at edge 2·`DEAD_CYC`.
- R4: After the command falls while `gate_lh` is on, `gate_lh` turns off at the first edge. Both left outputs stay off for `DEAD_CYC` cycles, and then `gate_ll` turns on.
- R5: `gate_lh` and `gate_ll` are never 1 together, `gate_rh` and `gate_rl` are never 1 together, and neither switch of a leg turns on in the cycle right after its partner was on.
- R6: A command pulse shorter than `DEAD_CYC` cycles produces no `gate_lh` pulse, and `gate_ll` stays on throughout.
- R7: While `bridge_off` is 1, the effective duty is 0. `gate_lh` is off from the first edge after `bridge_off` rises and stays off until the flag clears.
- R8: When `dir_fwd` is 1 the right leg settles with `gate_rh` on, and when it is 0 the right leg settles with `gate_rl` on.
- R9: A change of `dir_fwd` turns both right outputs off at the next edge for `DEAD_CYC` cycles. The switch chosen by `dir_fwd` when the gap ends then turns on.
- R10: If the command drops during the rising gap, `gate_lh` never turns on. `gate_ll` returns after a full `DEAD_CYC`-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | Duty command, 1 = drive left high side |
| dir_fwd | input | 1 | Direction select, 1 = forward (right high side), 0 = reverse (right low side) |
| bridge_off | input | 1 | Disable flag, 1 forces the duty to zero |
| gate_lh | output | 1 | Left high-side gate enable |
| gate_ll | output | 1 | Left low-side gate enable |
| gate_rh | output | 1 | Right high-side gate enable |
| gate_rl | output | 1 | Right low-side gate enable |

## Verification
Several properties are checked on every cycle: no shoot-through in either leg, at least one all-off cycle before any switch turns on, the high side rising only on a live enabled command, the disable flag cutting the high side at the next edge, the right leg landing on the side the direction selects, and all outputs being off in reset. The exact lengths of the gaps, the qualification window that filters short pulses, the abort path out of the rising gap and the right leg's choice after the direction flips back and forth inside the swap gap are cycle counts. Only the bench's directed scenarios can show these.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        L_LOW_ON   = 2'd0,
        L_RISE_GAP = 2'd1,
        L_HIGH_ON  = 2'd2,
        L_FALL_GAP = 2'd3
    } left_st_t;

    typedef enum logic [1:0] {
        R_FWD_ON   = 2'd0,
        R_REV_ON   = 2'd1,
        R_SWAP_GAP = 2'd2
    } right_st_t;

    function automatic int unsigned dwell_width(input int unsigned cycles);
        return (cycles < 2) ? 1 : $clog2(cycles);
    endfunction

endpackage

// File: rtl/hb_dwell_timer.sv
module hb_dwell_timer #(
    parameter int unsigned DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic done
);
    import hb_gate_pkg::*;

    localparam int unsigned CW     = dwell_width(DEAD_CYC);
    localparam int unsigned LAST_I = DEAD_CYC - 1;
    localparam logic [CW-1:0] LAST = LAST_I[CW-1:0];

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

endmodule

// File: rtl/hb_left_leg.sv
module hb_left_leg #(
    parameter int unsigned DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic duty_eff,
    output logic hi_on,
    output logic lo_on
);
    import hb_gate_pkg::*;

    left_st_t st, st_nx;
    logic     t_clr, t_adv, t_done;

    hb_dwell_timer #(.DEAD_CYC(DEAD_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .adv   (t_adv),
        .done  (t_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= L_FALL_GAP;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        t_clr = 1'b0;
        t_adv = 1'b0;
        unique case (st)
            L_LOW_ON: begin
                t_adv = duty_eff;
                t_clr = !duty_eff || t_done;
                if (duty_eff && t_done) st_nx = L_RISE_GAP;
            end
            L_RISE_GAP: begin
                t_adv = duty_eff;
                t_clr = !duty_eff || t_done;
                if (!duty_eff)   st_nx = L_FALL_GAP;
                else if (t_done) st_nx = L_HIGH_ON;
            end
            L_HIGH_ON: begin
                t_clr = 1'b1;
                if (!duty_eff) st_nx = L_FALL_GAP;
            end
            L_FALL_GAP: begin
                t_adv = 1'b1;
                t_clr = t_done;
                if (t_done) st_nx = L_LOW_ON;
            end
        endcase
    end

    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (st)
            L_LOW_ON:   lo_on = 1'b1;
            L_HIGH_ON:  hi_on = 1'b1;
            L_RISE_GAP,
            L_FALL_GAP: ;
        endcase
    end

endmodule

// File: rtl/hb_right_leg.sv
module hb_right_leg #(
    parameter int unsigned DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd,
    output logic hi_on,
    output logic lo_on
);
    import hb_gate_pkg::*;

    right_st_t st, st_nx;
    logic      t_clr, t_done;

    hb_dwell_timer #(.DEAD_CYC(DEAD_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .adv   (1'b1),
        .done  (t_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= R_SWAP_GAP;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        t_clr = 1'b1;
        unique case (st)
            R_FWD_ON: if (!fwd) st_nx = R_SWAP_GAP;
            R_REV_ON: if (fwd)  st_nx = R_SWAP_GAP;
            R_SWAP_GAP: begin
                t_clr = t_done;
                if (t_done) st_nx = fwd ? R_FWD_ON : R_REV_ON;
            end
            default: st_nx = R_SWAP_GAP;
        endcase
    end

    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (st)
            R_FWD_ON:   hi_on = 1'b1;
            R_REV_ON:   lo_on = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
    parameter int unsigned DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic dir_fwd,
    input  logic bridge_off,
    output logic gate_lh,
    output logic gate_ll,
    output logic gate_rh,
    output logic gate_rl
);

    logic duty_eff;

    assign duty_eff = pwm_cmd && !bridge_off;

    hb_left_leg #(.DEAD_CYC(DEAD_CYC)) u_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_eff (duty_eff),
        .hi_on    (gate_lh),
        .lo_on    (gate_ll)
    );

    hb_right_leg #(.DEAD_CYC(DEAD_CYC)) u_right (
        .clk   (clk),
        .rst_n (rst_n),
        .fwd   (dir_fwd),
        .hi_on (gate_rh),
        .lo_on (gate_rl)
    );

endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_cmd,
    input logic dir_fwd,
    input logic bridge_off,
    input logic gate_lh,
    input logic gate_ll,
    input logic gate_rh,
    input logic gate_rl
);

    AST_RST_ALL_OFF: assert property (@(posedge clk) !rst_n |-> !(gate_lh || gate_ll || gate_rh || gate_rl)); // R1

    AST_LEFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_lh && gate_ll)); // R5

    AST_RIGHT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_rh && gate_rl)); // R5

    AST_LH_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_lh) |-> $past(!gate_ll)); // R3

    AST_LL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_ll) |-> $past(!gate_lh)); // R4

    AST_RH_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_rh) |-> $past(!gate_rl)); // R9

    AST_RL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_rl) |-> $past(!gate_rh)); // R9

    AST_LH_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_lh) |-> $past(pwm_cmd && !bridge_off)); // R2

    AST_OFF_CUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bridge_off |=> !gate_lh); // R7

    AST_RH_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_rh) |-> $past(dir_fwd)); // R8

    AST_RL_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_rl) |-> $past(!dir_fwd)); // R8

endmodule

bind hb_gate_ctrl hb_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_cmd    (pwm_cmd),
    .dir_fwd    (dir_fwd),
    .bridge_off (bridge_off),
    .gate_lh    (gate_lh),
    .gate_ll    (gate_ll),
    .gate_rh    (gate_rh),
    .gate_rl    (gate_rl)
);

// File: tb/hb_gate_ctrl_tb_top.sv
module hb_gate_ctrl_tb_top;

    localparam int unsigned DC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic pwm_cmd = 1'b0;
    logic dir_fwd = 1'b1;
    logic bridge_off = 1'b0;
    logic gate_lh, gate_ll, gate_rh, gate_rl;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYC(DC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_cmd    (pwm_cmd),
        .dir_fwd    (dir_fwd),
        .bridge_off (bridge_off),
        .gate_lh    (gate_lh),
        .gate_ll    (gate_ll),
        .gate_rh    (gate_rh),
        .gate_rl    (gate_rl)
    );

    // Advance n rising edges, then settle 1 ns past the last one.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Expected order {lh, ll, rh, rl}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {gate_lh, gate_ll, gate_rh, gate_rl};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gates {lh,ll,rh,rl} = %b, expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        #1 rst_n = 1'b0;
        step(3);
        chk("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        step(DC - 1);
        chk("R1 gap after release", 4'b0000);
        step(1);
        chk("R1 low and fwd on", 4'b0110);
    endtask

    task automatic t_rise_fall;
        pwm_cmd = 1'b1;
        step(DC - 1);
        chk("R3 low held while qualifying", 4'b0110);
        step(1);
        chk("R3 low off at qualify", 4'b0010);
        step(DC - 1);
        chk("R3 gap held", 4'b0010);
        step(1);
        chk("R3 high on", 4'b1010);
        step(5);
        chk("R2 high steady", 4'b1010);
        pwm_cmd = 1'b0;
        step(1);
        chk("R4 high off at once", 4'b0010);
        step(DC - 1);
        chk("R4 gap held", 4'b0010);
        step(1);
        chk("R4 low back on", 4'b0110);
        step(4);
        chk("R2 low steady", 4'b0110);
    endtask

    task automatic t_short_pulse;
        pwm_cmd = 1'b1;
        step(DC - 1);
        chk("R6 low kept during short pulse", 4'b0110);
        pwm_cmd = 1'b0;
        step(1);
        chk("R6 no gap after short pulse", 4'b0110);
        step(2 * DC + 2);
        chk("R6 no high pulse", 4'b0110);
    endtask

    task automatic t_abort;
        pwm_cmd = 1'b1;
        step(DC);
        chk("R10 in rising gap", 4'b0010);
        step(3);
        pwm_cmd = 1'b0;
        step(1);
        chk("R10 abort keeps high off", 4'b0010);
        step(DC - 1);
        chk("R10 full gap on abort", 4'b0010);
        step(1);
        chk("R10 low back on", 4'b0110);
    endtask

    task automatic t_disable;
        pwm_cmd = 1'b1;
        step(2 * DC);
        chk("R7 high on before disable", 4'b1010);
        bridge_off = 1'b1;
        step(1);
        chk("R7 high cut next edge", 4'b0010);
        step(DC);
        chk("R7 low on while disabled", 4'b0110);
        step(3 * DC);
        chk("R7 duty held at zero", 4'b0110);
        bridge_off = 1'b0;
        step(2 * DC - 1);
        chk("R7 high still in gap after enable", 4'b0010);
        step(1);
        chk("R7 high resumes", 4'b1010);
        pwm_cmd = 1'b0;
        step(DC + 1);
        chk("R4 settle after disable test", 4'b0110);
    endtask

    task automatic t_direction;
        dir_fwd = 1'b0;
        step(1);
        chk("R9 right both off", 4'b0100);
        step(DC - 1);
        chk("R9 right gap held", 4'b0100);
        step(1);
        chk("R8 reverse low on", 4'b0101);
        dir_fwd = 1'b1;
        step(1);
        chk("R9 right both off on return", 4'b0100);
        step(DC);
        chk("R8 forward high on", 4'b0110);
        dir_fwd = 1'b0;
        step(2);
        dir_fwd = 1'b1;
        step(DC - 2);
        chk("R9 gap during bounce", 4'b0100);
        step(1);
        chk("R9 lands on final direction", 4'b0110);
    endtask

    task automatic t_both_legs;
        pwm_cmd = 1'b1;
        dir_fwd = 1'b0;
        step(2 * DC);
        chk("R5 left high with right low", 4'b1001);
        pwm_cmd = 1'b0;
        dir_fwd = 1'b1;
        step(DC + 1);
        chk("R5 both legs settle", 4'b0110);
    endtask

    initial begin
        t_reset();
        t_rise_fall();
        t_short_pulse();
        t_abort();
        t_disable();
        t_direction();
        t_both_legs();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual timeout, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule